// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Down Controller

This block decides when an SDRAM device is put to sleep by pulling its clock-enable pin low and when it is woken again. A power-down request comes from the power manager. The request is honoured only when the access sequencer reports that no access is in flight.

The block owns the command bus for the whole sleep episode. CKE falls and rises only in cycles where the block also forces a NOP/deselect onto the bus. One further NOP cycle follows wake-up before control goes back to the sequencer.

At entry the block samples the per-bank open-row status and reports the kind of sleep:

- precharge power-down when every bank is idle;
- active power-down when at least one row is open.

The reported mode stays frozen for the whole episode. A residency counter, sized from the clock frequency, wakes the device a set margin before the 64 ms refresh period has elapsed since entry. When it does, it also raises a one-cycle wake request to the refresh logic.

Top module: `sdram_cke_pdctl`

## Requirements
- R1: While reset is high and in the first cycle after it, `cke_o` is 1 and `force_nop_o`, `active_pd_o` and `wake_req_o` are 0.
- R2: When a request is seen and `seq_idle_i` is 1 at a clock edge, `cke_o` is 0 from that edge on. `force_nop_o` is 1 in every cycle in which `cke_o` is 0.
- R3: No entry happens while `seq_idle_i` is 0. A request (a 0-to-1 change of `pd_req_i`) seen while busy is kept pending, even if `pd_req_i` falls again. Entry then happens at the first edge with `seq_idle_i` at 1.
- R4: `active_pd_o` is 1 during power-down if any bit of `bank_open_i` was 1 at the entry edge, and 0 if all bits were 0.
- R5: `active_pd_o` does not change while `cke_o` stays 0, whatever `bank_open_i` does.
- R6: An edge at which `pd_req_i` is 0 during power-down makes `cke_o` 1 after that edge, with `force_nop_o` still 1 and `wake_req_o` 0.
- R7: With `pd_req_i` held high, `cke_o` stays 0 for exactly WAKE_CYC = (CLK_HZ/1000)·REFRESH_MS − MARGIN_CYC cycles. `wake_req_o` is then 1 for the single cycle in which `cke_o` has just returned to 1.
- R8: `force_nop_o` stays 1 for the cycle in which `cke_o` returns to 1 and for exactly one further cycle. It is 0 in the cycle after that.
- R9: After a forced wake, a `pd_req_i` that stays high causes no new entry. Only a fresh 0-to-1 change of `pd_req_i` starts a new episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_i | input | 1 | Power-down request; its rising edge asks for entry, its low level asks for exit |
| seq_idle_i | input | 1 | Access sequencer has no access in progress |
| bank_open_i | input | NUM_BANKS | One bit per bank, 1 when that bank holds an open row |
| cke_o | output | 1 | Clock-enable to the device |
| force_nop_o | output | 1 | Command bus must carry NOP/deselect; sequencer locked out |
| active_pd_o | output | 1 | 1 = active power-down, 0 = precharge power-down |
| wake_req_o | output | 1 | One-cycle pulse to the refresh logic on a forced wake |

## Verification
The checker watches the following rules on every cycle:

- CKE is never low without a forced NOP.
- CKE only falls after an idle cycle.
- The mode flag equals the bank status of the entry edge and stays frozen while CKE is low.
- A wake pulse appears only on the cycle CKE rises.
- The trailing NOP follows every rise.
- A residency counter never exceeds the wake limit.

Four behaviours can only be shown by the directed scenarios:

- the exact residency length;
- a pending request surviving a busy period and the request's own fall;
- the trailing NOP ending after exactly one cycle;
- the refusal to re-enter while a request stays high after a forced wake.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_DOWN  = 2'd1,
    PD_EXIT  = 2'd2,
    PD_GUARD = 2'd3
  } pd_state_t;
endpackage

// File: rtl/sdram_pd_req_track.sv
// Turns the request level into an entry demand: a rising edge is latched
// and held until the controller actually enters power-down.
module sdram_pd_req_track (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic entering_i,
  output logic go_o
);
  logic req_d_q;
  logic pend_q;
  logic rise;

  assign rise = req_i & ~req_d_q;
  assign go_o = pend_q | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      req_d_q <= req_i;
      if (entering_i)
        pend_q <= 1'b0;
      else if (rise)
        pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_pd_timer.sv
// Counts cycles spent with CKE low; flags expiry at WAKE_CYC.
module sdram_pd_timer #(
  parameter int WAKE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start_i)
      cnt_q <= CW'(1);
    else if (run_i && !expired_o)
      cnt_q <= cnt_q + CW'(1);
    else if (!run_i)
      cnt_q <= '0;
  end
endmodule

// File: rtl/sdram_pd_fsm.sv
// Sequencing of entry, residency, exit and the trailing NOP cycle.
module sdram_pd_fsm
  import sdram_pd_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 go_i,
  input  logic                 req_i,
  input  logic                 idle_i,
  input  logic                 expired_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 entering_o,
  output logic                 in_pd_o,
  output logic                 cke_o,
  output logic                 force_nop_o,
  output logic                 active_pd_o,
  output logic                 wake_req_o
);
  pd_state_t state_q;
  logic      leaving;

  assign entering_o = (state_q == PD_RUN) && go_i && idle_i;
  assign in_pd_o    = (state_q == PD_DOWN);
  assign leaving    = in_pd_o && (expired_i || !req_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PD_RUN;
      cke_o       <= 1'b1;
      force_nop_o <= 1'b0;
      active_pd_o <= 1'b0;
      wake_req_o  <= 1'b0;
    end else begin
      wake_req_o <= 1'b0;
      unique case (state_q)
        PD_RUN: begin
          if (entering_o) begin
            state_q     <= PD_DOWN;
            cke_o       <= 1'b0;
            force_nop_o <= 1'b1;
            active_pd_o <= |bank_open_i;
          end
        end
        PD_DOWN: begin
          if (leaving) begin
            state_q     <= PD_EXIT;
            cke_o       <= 1'b1;
            active_pd_o <= 1'b0;
            wake_req_o  <= expired_i;
          end
        end
        PD_EXIT: begin
          state_q <= PD_GUARD;
        end
        PD_GUARD: begin
          state_q     <= PD_RUN;
          force_nop_o <= 1'b0;
        end
        default: state_q <= PD_RUN;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cke_pdctl.sv
module sdram_cke_pdctl #(
  parameter int NUM_BANKS  = 4,
  parameter int CLK_HZ     = 100_000_000,
  parameter int REFRESH_MS = 64,
  parameter int MARGIN_CYC = 2048
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pd_req_i,
  input  logic                 seq_idle_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 cke_o,
  output logic                 force_nop_o,
  output logic                 active_pd_o,
  output logic                 wake_req_o
);
  localparam int LIMIT_CYC = (CLK_HZ / 1000) * REFRESH_MS;
  localparam int WAKE_CYC  = LIMIT_CYC - MARGIN_CYC;

  logic go, entering, in_pd, expired;

  sdram_pd_req_track req_i (
    .clk        (clk),
    .rst        (rst),
    .req_i      (pd_req_i),
    .entering_i (entering),
    .go_o       (go)
  );

  sdram_pd_timer #(.WAKE_CYC(WAKE_CYC)) tmr_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (entering),
    .run_i     (in_pd),
    .expired_o (expired)
  );

  sdram_pd_fsm #(.NUM_BANKS(NUM_BANKS)) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go),
    .req_i       (pd_req_i),
    .idle_i      (seq_idle_i),
    .expired_i   (expired),
    .bank_open_i (bank_open_i),
    .entering_o  (entering),
    .in_pd_o     (in_pd),
    .cke_o       (cke_o),
    .force_nop_o (force_nop_o),
    .active_pd_o (active_pd_o),
    .wake_req_o  (wake_req_o)
  );
endmodule

// File: rtl/sdram_cke_pdctl_chk.sv
module sdram_cke_pdctl_chk #(
  parameter int NUM_BANKS = 4,
  parameter int WAKE_CYC  = 1024
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 seq_idle_i,
  input logic [NUM_BANKS-1:0] bank_open_i,
  input logic                 cke_o,
  input logic                 force_nop_o,
  input logic                 active_pd_o,
  input logic                 wake_req_o
);
  int low_cnt;

  always_ff @(posedge clk) begin
    if (rst || cke_o) low_cnt <= 0;
    else              low_cnt <= low_cnt + 1;
  end

  AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (rst) !cke_o |-> force_nop_o); // R2
  AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst) $fell(cke_o) |-> $past(seq_idle_i)); // R3
  AST_MODE_CLASS: assert property (@(posedge clk) disable iff (rst) $fell(cke_o) |-> (active_pd_o == $past(|bank_open_i))); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst) (!cke_o && $past(!cke_o)) |-> $stable(active_pd_o)); // R5
  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (rst) wake_req_o |-> $rose(cke_o)); // R7
  AST_RESIDENCY_LIMIT: assert property (@(posedge clk) disable iff (rst) low_cnt <= WAKE_CYC); // R7
  AST_EXIT_GUARD: assert property (@(posedge clk) disable iff (rst) $rose(cke_o) |=> force_nop_o); // R8
endmodule

bind sdram_cke_pdctl sdram_cke_pdctl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .WAKE_CYC  (WAKE_CYC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .seq_idle_i  (seq_idle_i),
  .bank_open_i (bank_open_i),
  .cke_o       (cke_o),
  .force_nop_o (force_nop_o),
  .active_pd_o (active_pd_o),
  .wake_req_o  (wake_req_o)
);

// File: tb/sdram_cke_pdctl_tb_top.sv
`timescale 1ns/1ps
module sdram_cke_pdctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int HZ         = 1000;
  localparam int RMS        = 64;
  localparam int MARGIN     = 8;
  localparam int EXP_WAKE   = (HZ / 1000) * RMS - MARGIN;

  logic clk = 1'b0;
  logic rst;
  logic pd_req, idle;
  logic [NB-1:0] banks;
  logic cke, nop, act, wake;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cke_pdctl #(
    .NUM_BANKS(NB), .CLK_HZ(HZ), .REFRESH_MS(RMS), .MARGIN_CYC(MARGIN)
  ) dut_i (
    .clk(clk), .rst(rst), .pd_req_i(pd_req), .seq_idle_i(idle),
    .bank_open_i(banks), .cke_o(cke), .force_nop_o(nop),
    .active_pd_o(act), .wake_req_o(wake)
  );

  task automatic chk(input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; pd_req = 1'b0; idle = 1'b1; banks = '0;
    tick(3);
    chk("R1 cke in reset", cke, 1);
    chk("R1 nop in reset", nop, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 cke after reset", cke, 1);
    chk("R1 nop after reset", nop, 0);
    chk("R1 mode after reset", act, 0);
    chk("R1 wake after reset", wake, 0);
  endtask

  task automatic t_precharge_pd();
    pd_req = 1'b1; idle = 1'b1; banks = '0;
    tick(1);
    chk("R2 cke low on entry", cke, 0);
    chk("R2 nop with cke low", nop, 1);
    chk("R4 precharge mode", act, 0);
    banks = 4'b1111;
    tick(3);
    chk("R5 mode frozen", act, 0);
    chk("R2 still down", cke, 0);
    pd_req = 1'b0;
    tick(1);
    chk("R6 cke high on exit", cke, 1);
    chk("R6 nop on exit cycle", nop, 1);
    chk("R6 no wake on requested exit", wake, 0);
    tick(1);
    chk("R8 extra nop cycle", nop, 1);
    tick(1);
    chk("R8 bus released", nop, 0);
    banks = '0;
  endtask

  task automatic t_pending();
    idle = 1'b0; banks = 4'b0100;
    pd_req = 1'b1;
    tick(1);
    pd_req = 1'b0;
    tick(4);
    chk("R3 no entry while busy", cke, 1);
    chk("R3 bus free while busy", nop, 0);
    idle = 1'b1;
    tick(1);
    chk("R3 pending entry on idle", cke, 0);
    chk("R4 active mode", act, 1);
    tick(1);
    chk("R6 exit since request low", cke, 1);
    tick(2);
    chk("R8 released after pending episode", nop, 0);
    banks = '0;
  endtask

  task automatic t_timeout();
    int n;
    pd_req = 1'b1; idle = 1'b1; banks = 4'b0001;
    tick(1);
    n = 0;
    while (cke == 1'b0 && n < 500) begin
      n++;
      tick(1);
    end
    chk("R7 residency cycles", n, EXP_WAKE);
    chk("R7 wake pulse on rise", wake, 1);
    chk("R7 cke high after limit", cke, 1);
    tick(1);
    chk("R7 wake is one cycle", wake, 0);
    chk("R8 extra nop after forced wake", nop, 1);
    tick(10);
    chk("R9 no re-entry while request held", cke, 1);
    chk("R9 bus free while request held", nop, 0);
    pd_req = 1'b0;
    tick(1);
    pd_req = 1'b1;
    tick(1);
    chk("R9 fresh request enters", cke, 0);
    pd_req = 1'b0;
    tick(3);
    chk("R8 idle after final episode", nop, 0);
  endtask

  initial begin
    t_reset();
    t_precharge_pd();
    t_pending();
    t_timeout();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule